// File: doc/BRIEF.md
# Redundant-Copy Majority Decoder for Read-Retry Tables

This block rebuilds a read-retry parameter table from a byte image whose contents cannot be trusted one byte at a time. Every quantity in the image appears eight times. The block reads the image from a buffer memory through a simple read port that returns data one cycle after the request. It first settles how many retry modes and how many registers per mode the table holds. It then settles each table entry in turn and writes it to an output table port.

Each quantity is settled by a majority rule. Only the first half of the copies can be candidates. A candidate is accepted when more than half the copy count of the copies after it equal it. If the plain copies of an entry cannot agree, the block tries the bit-inverted copies of the same entry and writes the complement of the accepted byte. If neither set agrees, or if the decoded table shape is unusable, the block stops and raises an error flag.

A controller pulses `start`, waits for `done` or `err`, and then takes the table it has collected from the write port, together with the two counts.

Top module: `rr_vote_decoder`

## Requirements
- R1: The mode count is voted from image bytes 0..7 and the register count from bytes 8..15. Both appear on `modes_out` and `regs_out` once the run completes.
- R2: A vote over eight copies c0..c7 tests only c0..c3 as candidates, in index order. Candidate ci wins when the number of cj with j>i and cj==ci is greater than 4. The first winner is the result, and a vote with no winner fails.
- R3: With S = modes*registers and entry index e = mode*registers + register, plain copy k of entry e is at byte 16 + 2*k*S + e. The accepted value is written with `tbl_addr` equal to e.
- R4: Inverted copy k of entry e is at byte 16 + (2*k+1)*S + e. It is used only when the plain vote for that entry fails, and the bitwise complement of the winning byte is written.
- R5: When both the plain and the inverted votes fail for an entry, or the vote on a count fails, `err` rises, `busy` falls and no further table writes occur.
- R6: A mode count of zero, a register count of zero, or a product greater than MAX_ENTRIES (default 64) sets `err` and writes no table entry. A product equal to MAX_ENTRIES is decoded in full.
- R7: Entries are written exactly once each, in ascending e. `done` is a one-cycle pulse in the same cycle as the last write, and it does not occur on an error.
- R8: After reset, `busy`, `done`, `err`, `tbl_we` and `mem_rd` are all low.
- R9: A `start` pulse while `busy` is high is ignored. The run in progress completes unchanged.
- R10: Read data is taken from `mem_data` exactly one cycle after the matching `mem_rd` cycle. `mem_rd` is low whenever the block is idle.
- R11: `err` stays high until the next accepted `start`, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a decode (accepted only when idle) |
| mem_rd | output | 1 | Read request to the buffer memory |
| mem_addr | output | ADDR_W | Byte address of the read |
| mem_data | input | DATA_W | Read data, valid one cycle after `mem_rd` |
| tbl_we | output | 1 | Table entry write strobe |
| tbl_addr | output | $clog2(MAX_ENTRIES) | Table entry index e |
| tbl_data | output | DATA_W | Table entry value |
| modes_out | output | DATA_W | Voted mode count |
| regs_out | output | DATA_W | Voted register count |
| busy | output | 1 | Decode in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| err | output | 1 | Decode aborted |

## Verification
Images are built with chosen copy positions corrupted to distinct wrong values. This shows that clean data is accepted by the first candidate. It also shows that one or two leading bad copies move the winner to a later candidate, that three bad copies at the front or at the back (five of eight agreeing) defeat the plain vote, and that the inverted copies then recover the true value. Other images have corrupted counts, zero counts, an oversized shape and a shape exactly at capacity. These separate the count-vote failure, the geometry error and the largest legal table. Separate tests cover a restart attempted mid-run and an error cleared by a later start.

// File: rtl/rr_vote_decoder.sv
module rr_vote_decoder #(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 8,
  parameter int COPIES      = 8,
  parameter int MAX_ENTRIES = 64
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start,
  output logic                           mem_rd,
  output logic [ADDR_W-1:0]              mem_addr,
  input  logic [DATA_W-1:0]              mem_data,
  output logic                           tbl_we,
  output logic [$clog2(MAX_ENTRIES)-1:0] tbl_addr,
  output logic [DATA_W-1:0]              tbl_data,
  output logic [DATA_W-1:0]              modes_out,
  output logic [DATA_W-1:0]              regs_out,
  output logic                           busy,
  output logic                           done,
  output logic                           err
);
  localparam int HALF     = COPIES / 2;
  localparam int CW       = $clog2(COPIES + 1);
  localparam int IW       = $clog2(COPIES);
  localparam int TW       = $clog2(MAX_ENTRIES);
  localparam int PW       = 2 * DATA_W;
  localparam int BODY_OFS = 2 * COPIES;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_VOTE} st_t;
  typedef enum logic [1:0] {P_MODES, P_REGS, P_VALS} ph_t;

  st_t st;
  ph_t ph;
  logic [DATA_W-1:0] copies [COPIES];
  logic [ADDR_W-1:0] addr_q, stride_q;
  logic [CW-1:0]     issued, captured, hits;
  logic              rd_q, inv_q;
  logic [IW-1:0]     cand, probe;
  logic [TW-1:0]     ent;
  logic [PW-1:0]     size_q;
  logic [DATA_W-1:0] modes_q, regs_q;

  logic [DATA_W-1:0] voted;
  logic [CW-1:0]     hits_nx;
  logic [PW-1:0]     prod;
  logic              last_probe, win, lose, bad_geom, last_ent;

  assign busy       = (st != S_IDLE);
  assign mem_rd     = (st == S_FETCH) && (issued < CW'(COPIES));
  assign mem_addr   = addr_q;
  assign modes_out  = modes_q;
  assign regs_out   = regs_q;

  assign voted      = copies[cand];
  assign hits_nx    = hits + CW'(copies[probe] == voted);
  assign last_probe = (probe == IW'(COPIES - 1));
  assign win        = last_probe && (hits_nx > CW'(HALF));
  assign lose       = last_probe && !win && (cand == IW'(HALF - 1));
  assign prod       = PW'(modes_q) * PW'(voted);
  assign bad_geom   = (modes_q == '0) || (voted == '0) || (prod > PW'(MAX_ENTRIES));
  assign last_ent   = (PW'(ent) == size_q - PW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      ph       <= P_MODES;
      addr_q   <= '0;
      stride_q <= '0;
      issued   <= '0;
      captured <= '0;
      hits     <= '0;
      rd_q     <= 1'b0;
      inv_q    <= 1'b0;
      cand     <= '0;
      probe    <= '0;
      ent      <= '0;
      size_q   <= '0;
      modes_q  <= '0;
      regs_q   <= '0;
      tbl_we   <= 1'b0;
      tbl_addr <= '0;
      tbl_data <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
      for (int k = 0; k < COPIES; k++) copies[k] <= '0;
    end else begin
      tbl_we <= 1'b0;
      done   <= 1'b0;
      rd_q   <= mem_rd;
      case (st)
        S_IDLE: begin
          if (start) begin
            err      <= 1'b0;
            ph       <= P_MODES;
            st       <= S_FETCH;
            issued   <= '0;
            captured <= '0;
            addr_q   <= '0;
            stride_q <= ADDR_W'(1);
          end
        end
        S_FETCH: begin
          if (mem_rd) begin
            addr_q <= addr_q + stride_q;
            issued <= issued + 1'b1;
          end
          if (rd_q) begin
            copies[captured[IW-1:0]] <= mem_data;
            captured <= captured + 1'b1;
            if (captured == CW'(COPIES - 1)) begin
              st    <= S_VOTE;
              cand  <= '0;
              probe <= IW'(1);
              hits  <= '0;
            end
          end
        end
        S_VOTE: begin
          if (!last_probe) begin
            probe <= probe + 1'b1;
            hits  <= hits_nx;
          end else if (win) begin
            issued   <= '0;
            captured <= '0;
            case (ph)
              P_MODES: begin
                modes_q  <= voted;
                ph       <= P_REGS;
                st       <= S_FETCH;
                addr_q   <= ADDR_W'(COPIES);
                stride_q <= ADDR_W'(1);
              end
              P_REGS: begin
                regs_q <= voted;
                if (bad_geom) begin
                  err <= 1'b1;
                  st  <= S_IDLE;
                end else begin
                  size_q   <= prod;
                  ent      <= '0;
                  inv_q    <= 1'b0;
                  ph       <= P_VALS;
                  st       <= S_FETCH;
                  addr_q   <= ADDR_W'(BODY_OFS);
                  stride_q <= ADDR_W'(2 * int'(prod));
                end
              end
              default: begin
                tbl_we   <= 1'b1;
                tbl_addr <= ent;
                tbl_data <= inv_q ? ~voted : voted;
                if (last_ent) begin
                  done <= 1'b1;
                  st   <= S_IDLE;
                end else begin
                  ent    <= ent + 1'b1;
                  inv_q  <= 1'b0;
                  st     <= S_FETCH;
                  addr_q <= ADDR_W'(BODY_OFS + int'(ent) + 1);
                end
              end
            endcase
          end else if (lose) begin
            if (ph == P_VALS && !inv_q) begin
              inv_q    <= 1'b1;
              st       <= S_FETCH;
              issued   <= '0;
              captured <= '0;
              addr_q   <= ADDR_W'(BODY_OFS + int'(size_q) + int'(ent));
            end else begin
              err <= 1'b1;
              st  <= S_IDLE;
            end
          end else begin
            cand  <= cand + 1'b1;
            probe <= cand + IW'(2);
            hits  <= '0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_err_blocks_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!tbl_we && !done));

  assert_write_in_shape_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_we |-> (32'(tbl_addr) < 32'(modes_out) * 32'(regs_out)));

  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !start) |=> err);

  assert_no_read_at_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) |-> !mem_rd);

  assert_no_write_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> !tbl_we);
endmodule

// File: tb/rr_vote_decoder_test.sv
module rr_vote_decoder_test;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 8;
  localparam int MAXE   = 64;
  localparam int MEMSZ  = 1 << ADDR_W;
  localparam int NVEC   = 13;

  // modes, regs, count-corruption mask, plain mask, inverted mask, expect error
  localparam logic [40:0] VECS [NVEC] = '{
    {8'd4, 8'd3, 8'h00, 8'h00, 8'h00, 1'b0},
    {8'd4, 8'd3, 8'h00, 8'h01, 8'h00, 1'b0},
    {8'd4, 8'd3, 8'h00, 8'h03, 8'h00, 1'b0},
    {8'd4, 8'd3, 8'h00, 8'h07, 8'h00, 1'b0},
    {8'd4, 8'd3, 8'h00, 8'hE0, 8'h00, 1'b0},
    {8'd4, 8'd3, 8'h00, 8'h07, 8'h07, 1'b1},
    {8'd4, 8'd3, 8'h07, 8'h00, 8'h00, 1'b1},
    {8'd0, 8'd3, 8'h00, 8'h00, 8'h00, 1'b1},
    {8'd9, 8'd8, 8'h00, 8'h00, 8'h00, 1'b1},
    {8'd8, 8'd8, 8'h00, 8'h00, 8'h00, 1'b0},
    {8'd1, 8'd1, 8'h00, 8'h00, 8'h00, 1'b0},
    {8'd5, 8'd2, 8'h80, 8'h80, 8'h00, 1'b0},
    {8'd3, 8'd5, 8'h03, 8'h0F, 8'h01, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic mem_rd, tbl_we, busy, done, err;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_data, tbl_data, modes_out, regs_out;
  logic [$clog2(MAXE)-1:0] tbl_addr;

  logic [7:0] mem [MEMSZ];
  logic [7:0] got [MAXE];
  int nwr = 0, order_bad = 0, nchk = 0, nerr = 0, cyc = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rr_vote_decoder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .COPIES(8), .MAX_ENTRIES(MAXE)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_data(mem_data), .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
    .modes_out(modes_out), .regs_out(regs_out), .busy(busy), .done(done), .err(err));

  always_ff @(posedge clk) if (mem_rd) mem_data <= mem[mem_addr];

  always @(negedge clk) begin
    cyc++;
    if (tbl_we) begin
      if (int'(tbl_addr) != nwr) order_bad++;
      got[tbl_addr] = tbl_data;
      nwr++;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] val_of(input int sc, input int e);
    return 8'(e * 29 + 3 + sc * 7);
  endfunction

  task automatic build(input int sc, input logic [40:0] v);
    int m = int'(v[40:33]), r = int'(v[32:25]), s;
    logic [7:0] cm = v[24:17], pm = v[16:9], im = v[8:1];
    s = m * r;
    for (int a = 0; a < MEMSZ; a++) mem[a] = 8'hEE;
    for (int k = 0; k < 8; k++) begin
      mem[k]     = cm[k] ? 8'(m) ^ 8'(8'h20 + k) : 8'(m);
      mem[8 + k] = cm[k] ? 8'(r) ^ 8'(8'h40 + k) : 8'(r);
    end
    if (s > 0 && s <= MAXE)
      for (int e = 0; e < s; e++)
        for (int k = 0; k < 8; k++) begin
          mem[16 + 2*k*s + e]     = pm[k] ? val_of(sc, e) ^ 8'(8'h10 + k) : val_of(sc, e);
          mem[16 + (2*k+1)*s + e] = im[k] ? ~val_of(sc, e) ^ 8'(8'h10 + k) : ~val_of(sc, e);
        end
  endtask

  task automatic launch();
    for (int e = 0; e < MAXE; e++) got[e] = 8'h00;
    nwr = 0;
    order_bad = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_end(input string tag);
    int lim = 0;
    while (!(done || err) && lim < 20000) begin
      @(negedge clk);
      lim++;
    end
    check(lim < 20000, tag, lim, 0);
    @(negedge clk);
  endtask

  task automatic verify(input int sc, input logic [40:0] v, input string tag);
    int m = int'(v[40:33]), r = int'(v[32:25]), bad = 0;
    check(err == v[0], {tag, " err"}, int'(err), int'(v[0]));
    if (!v[0]) begin
      check(modes_out == 8'(m), "R1 modes", int'(modes_out), m);
      check(regs_out == 8'(r), "R1 regs", int'(regs_out), r);
      check(nwr == m * r, "R7 write count", nwr, m * r);
      check(order_bad == 0, "R7 write order", order_bad, 0);
      for (int e = 0; e < m * r; e++) if (got[e] != val_of(sc, e)) bad++;
      check(bad == 0, {tag, " table mismatches"}, bad, 0);
    end else begin
      check(nwr == 0, "R5 R6 no writes on error", nwr, 0);
    end
    check(!busy && !mem_rd, "R10 idle after run", int'(busy), 0);
  endtask

  function automatic string tag_of(input int i);
    case (i)
      0, 10:   return "R3";
      1, 2, 11: return "R2";
      3, 4, 12: return "R4";
      5:       return "R5";
      6:       return "R5 count";
      7, 8:    return "R6";
      default: return "R6 capacity";
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !err && !tbl_we && !mem_rd, "R8 reset outputs",
          int'({busy, done, err, tbl_we, mem_rd}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      build(i, VECS[i]);
      launch();
      wait_end(tag_of(i));
      verify(i, VECS[i], tag_of(i));
    end

    // R9: start during a run has no effect
    build(0, VECS[0]);
    launch();
    repeat (5) @(negedge clk);
    check(busy == 1'b1, "R9 busy mid-run", int'(busy), 1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_end("R9");
    check(nwr == 12, "R9 restart ignored", nwr, 12);
    check(order_bad == 0, "R9 order kept", order_bad, 0);

    // R11: error holds, then cleared by a new start
    build(5, VECS[5]);
    launch();
    wait_end("R11");
    repeat (4) @(negedge clk);
    check(err == 1'b1, "R11 err held", int'(err), 1);
    build(0, VECS[0]);
    launch();
    check(err == 1'b0, "R11 err cleared", int'(err), 0);
    wait_end("R11 rerun");
    verify(0, VECS[0], "R11 rerun");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    while (cyc < 150000) @(negedge clk);
    if (!finished) begin
      check(1'b0, "watchdog", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule